// File: doc/BRIEF.md
# Configurable Asynchronous Serial Receiver

This block turns one asynchronous serial input line into characters. The line is sampled at a base-clock enable supplied from outside, so the block needs no divider of its own. Configuration inputs set the character length (7, 8 or 9 bits), the parity check (off, even or odd), one or two stop bits, the bit order, and an optional inversion of the stored data. They also set the number of base clocks per bit (16, 8 or 6) and whether a frame starts on a low level or on a falling edge.

Each completed character is presented with its multi-processor bit, sticky parity, framing and overrun flags, and a one-cycle strobe. A wake-up filter can discard data frames until an ID frame arrives, and then disarms itself. A compare unit raises a sticky match flag when the low eight data bits equal a programmed value. The compare can optionally be limited to ID frames. All flags clear together on one explicit clear input.

Top module: `async_rx_core`

## Requirements
- R1: After reset, rx_data is 0 and rx_mpb, rx_strobe, rx_full, err_parity, err_frame, err_overrun, cmp_match and mp_wake_on are all 0.
- R2: cfg_len_code selects the character length. When bit 1 is 0 the length is 9 bits. Code 2'b10 gives 8 bits and code 2'b11 gives 7 bits. Unused upper bits of rx_data read 0.
- R3: With cfg_par_en set, a parity bit follows the data bits. cfg_par_odd=0 requires an even count of ones over the data and parity bits, and cfg_par_odd=1 requires an odd count. A mismatch sets err_parity.
- R4: cfg_stop2 selects one stop bit (0) or two stop bits (1). A low level at any stop-bit sample sets err_frame.
- R5: A bit lasts 16 base ticks. With cfg_os8 set it lasts 8, and with cfg_os6 set it lasts 6 whatever cfg_os8 is. Bits are sampled only on cycles where base_tick is high.
- R6: With cfg_edge_start=0, a low level on the line starts a frame. With cfg_edge_start=1, only a high-to-low transition starts one, so a line held low produces a single frame.
- R7: A start bit is confirmed half a bit period after detection. If the line is high at that point, the frame is abandoned and no flag or strobe results.
- R8: With cfg_msb_first=0, the first data bit received is bit 0. With cfg_msb_first=1, the first data bit received is the top bit of the character.
- R9: With cfg_invert set, rx_data holds the bitwise complement of the received data bits. The parity check still uses the line values.
- R10: With cfg_mp_mode set, one extra bit follows the parity position (or the data when parity is off). This bit is reported on rx_mpb: 1 marks an ID frame and 0 a data frame.
- R11: A pulse on mp_wake_arm sets mp_wake_on. While mp_wake_on is set in multi-processor mode, frames with the extra bit 0 are dropped with no strobe and no change of any flag. A frame with the extra bit 1 clears mp_wake_on and is received normally.
- R12: With cmp_enable set, an accepted character whose low eight bits equal cmp_value sets cmp_match. With cmp_id_only also set, only frames whose extra bit is 1 are compared.
- R13: rx_strobe pulses and rx_full sets when a character is accepted. If a character completes while rx_full is already set, it is dropped: rx_data keeps its value and err_overrun sets.
- R14: A flag_clr pulse clears rx_full, err_parity, err_frame, err_overrun and cmp_match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| base_tick | input | 1 | Base-clock enable, one cycle wide |
| rxd | input | 1 | Serial input line, idle high |
| cfg_len_code | input | 2 | Character length code |
| cfg_par_en | input | 1 | Parity bit present and checked |
| cfg_par_odd | input | 1 | 0 even parity, 1 odd parity |
| cfg_stop2 | input | 1 | Two stop bits |
| cfg_msb_first | input | 1 | Data arrives top bit first |
| cfg_invert | input | 1 | Store complemented data |
| cfg_os8 | input | 1 | 8 base ticks per bit |
| cfg_os6 | input | 1 | 6 base ticks per bit, overrides cfg_os8 |
| cfg_edge_start | input | 1 | Start on falling edge instead of low level |
| cfg_mp_mode | input | 1 | Frames carry an ID/data marker bit |
| mp_wake_arm | input | 1 | Pulse that arms the wake-up filter |
| cmp_enable | input | 1 | Enable data compare |
| cmp_id_only | input | 1 | Compare ID frames only |
| cmp_value | input | 8 | Compare value |
| flag_clr | input | 1 | Pulse that clears all flags |
| rx_data | output | 9 | Last accepted character |
| rx_mpb | output | 1 | Marker bit of last accepted character |
| rx_strobe | output | 1 | One-cycle pulse on acceptance |
| rx_full | output | 1 | Character waiting |
| err_parity | output | 1 | Sticky parity error |
| err_frame | output | 1 | Sticky framing error |
| err_overrun | output | 1 | Sticky overrun |
| cmp_match | output | 1 | Sticky compare match |
| mp_wake_on | output | 1 | Wake-up filter armed |

## Verification
Characters are sent in all three lengths and with both bit orders and inversion. Asymmetric values are chosen so that a swapped order, a dropped bit or a missing complement each give a different word. Parity frames are sent correct and corrupted in both senses. Frames with one bad stop bit and with the second of two stop bits bad show whether every stop sample is checked. The 16, 8 and 6 tick periods, including a sparse tick, would each corrupt data if the wrong period were used. A short low glitch and a long held-low break separate start confirmation from start detection, and level starts from edge starts (overrun versus none). Marker-bit sequences through the armed filter, compare values with and without the ID gate, and back-to-back characters without a clear probe the filter, the compare gating and the overrun path.

// File: rtl/arx_pkg.sv
package arx_pkg;
  localparam int MAX_DATA    = 9;
  localparam int MAX_FRAME   = 13;
  localparam int FRAME_IDX_W = $clog2(MAX_FRAME + 1);
  localparam int PERIOD_W    = 5;
  localparam int CMP_W       = 8;

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_BITS} rx_state_t;

  typedef struct packed {
    logic [MAX_DATA-1:0] data;
    logic                mpb;
    logic                perr;
    logic                ferr;
  } rx_word_t;

  // base ticks per bit; the six-tick select wins over the eight-tick select
  function automatic logic [PERIOD_W-1:0] bit_period(input logic os8, input logic os6);
    if (os6) return PERIOD_W'(6);
    if (os8) return PERIOD_W'(8);
    return PERIOD_W'(16);
  endfunction

  function automatic logic [FRAME_IDX_W-1:0] char_len(input logic [1:0] code);
    if (!code[1]) return FRAME_IDX_W'(9);
    return code[0] ? FRAME_IDX_W'(7) : FRAME_IDX_W'(8);
  endfunction

  // bits sampled after the start bit
  function automatic logic [FRAME_IDX_W-1:0] frame_len(input logic [FRAME_IDX_W-1:0] len,
      input logic pe, input logic mp, input logic two);
    return len + FRAME_IDX_W'(pe) + FRAME_IDX_W'(mp) + FRAME_IDX_W'(two) + FRAME_IDX_W'(1);
  endfunction

  function automatic rx_word_t unpack_frame(input logic [MAX_FRAME-1:0] frm,
      input logic [FRAME_IDX_W-1:0] len, input logic pe, input logic odd, input logic mp,
      input logic two, input logic msb, input logic inv);
    rx_word_t w;
    logic     par;
    int       p;
    w   = '0;
    par = odd;
    for (int i = 0; i < MAX_DATA; i++) begin
      if (i < int'(len)) begin
        if (msb) w.data[int'(len) - 1 - i] = frm[i];
        else     w.data[i] = frm[i];
        par = par ^ frm[i];
      end
    end
    if (inv) begin
      for (int i = 0; i < MAX_DATA; i++)
        if (i < int'(len)) w.data[i] = ~w.data[i];
    end
    p = int'(len);
    if (pe) begin
      w.perr = par ^ frm[p];
      p = p + 1;
    end
    if (mp) begin
      w.mpb = frm[p];
      p = p + 1;
    end
    w.ferr = ~frm[p];
    if (two) w.ferr = w.ferr | ~frm[p + 1];
    return w;
  endfunction
endpackage

// File: rtl/arx_sampler.sv
module arx_sampler
  import arx_pkg::*;
#(
  parameter int FRAME_W = MAX_FRAME,
  parameter int PER_W   = PERIOD_W,
  localparam int IDX_W  = $clog2(FRAME_W + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               base_tick,
  input  logic               rxd,
  input  logic               edge_start,
  input  logic [PER_W-1:0]   period,
  input  logic [IDX_W-1:0]   nbits,
  output logic [FRAME_W-1:0] frame,
  output logic               frame_done
);
  rx_state_t        st;
  logic             sync1, sync2, prev;
  logic [PER_W-1:0] cnt;
  logic [IDX_W-1:0] idx;
  logic             start_seen, half_hit, bit_hit, last_hit, glitch_abort;

  assign start_seen   = edge_start ? (prev & ~sync2) : ~sync2;
  assign half_hit     = base_tick && (st == RX_START) && (cnt == (period >> 1) - PER_W'(1));
  assign bit_hit      = base_tick && (st == RX_BITS) && (cnt == period - PER_W'(1));
  assign last_hit     = bit_hit && (idx == nbits - IDX_W'(1));
  assign glitch_abort = half_hit && sync2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1      <= 1'b1;
      sync2      <= 1'b1;
      prev       <= 1'b1;
      st         <= RX_IDLE;
      cnt        <= '0;
      idx        <= '0;
      frame      <= '0;
      frame_done <= 1'b0;
    end else begin
      sync1      <= rxd;
      sync2      <= sync1;
      frame_done <= last_hit;
      if (base_tick) prev <= sync2;
      case (st)
        RX_IDLE: if (base_tick && start_seen) begin
          st  <= RX_START;
          cnt <= '0;
        end
        RX_START: if (base_tick) begin
          if (half_hit) begin
            cnt <= '0;
            idx <= '0;
            st  <= sync2 ? RX_IDLE : RX_BITS;
          end else begin
            cnt <= cnt + PER_W'(1);
          end
        end
        RX_BITS: if (base_tick) begin
          if (bit_hit) begin
            cnt        <= '0;
            frame[idx] <= sync2;
            idx        <= idx + IDX_W'(1);
            if (last_hit) st <= RX_IDLE;
          end else begin
            cnt <= cnt + PER_W'(1);
          end
        end
        default: st <= RX_IDLE;
      endcase
    end
  end

  AST_PERIOD_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (st != RX_IDLE) |-> (cnt < period)); // R5
  AST_GLITCH_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    glitch_abort |=> (st == RX_IDLE)); // R7
  AST_START_AFTER_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == RX_START) && ($past(st) == RX_IDLE)) |-> !$past(sync2)); // R6
endmodule

// File: rtl/arx_decoder.sv
module arx_decoder
  import arx_pkg::*;
(
  input  logic [MAX_FRAME-1:0]   frame,
  input  logic [FRAME_IDX_W-1:0] len,
  input  logic                   par_en,
  input  logic                   par_odd,
  input  logic                   mp_mode,
  input  logic                   stop2,
  input  logic                   msb_first,
  input  logic                   invert,
  output rx_word_t               word
);
  always_comb word = unpack_frame(frame, len, par_en, par_odd, mp_mode, stop2, msb_first, invert);
endmodule

// File: rtl/arx_flags.sv
module arx_flags
  import arx_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                frame_done,
  input  rx_word_t            word,
  input  logic                mp_mode,
  input  logic                wake_arm,
  input  logic                cmp_enable,
  input  logic                cmp_id_only,
  input  logic [CMP_W-1:0]    cmp_value,
  input  logic                flag_clr,
  output logic [MAX_DATA-1:0] rx_data,
  output logic                rx_mpb,
  output logic                rx_strobe,
  output logic                rx_full,
  output logic                err_parity,
  output logic                err_frame,
  output logic                err_overrun,
  output logic                cmp_match,
  output logic                wake_on
);
  logic discard, accept, take, take_ovr, cmp_hit, wake_release;

  assign discard      = frame_done && mp_mode && wake_on && !word.mpb;
  assign wake_release = frame_done && mp_mode && wake_on && word.mpb;
  assign accept       = frame_done && !discard;
  assign take         = accept && !rx_full;
  assign take_ovr     = accept && rx_full;
  assign cmp_hit      = cmp_enable && (!cmp_id_only || word.mpb) && (word.data[CMP_W-1:0] == cmp_value);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data     <= '0;
      rx_mpb      <= 1'b0;
      rx_strobe   <= 1'b0;
      rx_full     <= 1'b0;
      err_parity  <= 1'b0;
      err_frame   <= 1'b0;
      err_overrun <= 1'b0;
      cmp_match   <= 1'b0;
      wake_on     <= 1'b0;
    end else begin
      rx_strobe <= take;
      if (flag_clr) begin
        rx_full     <= 1'b0;
        err_parity  <= 1'b0;
        err_frame   <= 1'b0;
        err_overrun <= 1'b0;
        cmp_match   <= 1'b0;
      end
      if (take_ovr) err_overrun <= 1'b1;
      if (take) begin
        rx_data <= word.data;
        rx_mpb  <= word.mpb;
        rx_full <= 1'b1;
        if (word.perr) err_parity <= 1'b1;
        if (word.ferr) err_frame  <= 1'b1;
        if (cmp_hit)   cmp_match  <= 1'b1;
      end
      if (wake_arm) wake_on <= 1'b1;
      else if (wake_release) wake_on <= 1'b0;
    end
  end

  AST_STROBE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    rx_strobe |-> rx_full); // R13
  AST_OVR_HOLDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    take_ovr |=> (err_overrun && $stable(rx_data))); // R13
  AST_DISCARD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (discard && !flag_clr) |=> (!rx_strobe && $stable(rx_full) && $stable(err_frame) && $stable(err_overrun))); // R11
  AST_WAKE_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_release && !wake_arm) |=> !wake_on); // R11
  AST_CLEAR_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !frame_done) |=> !(rx_full || err_parity || err_frame || err_overrun || cmp_match)); // R14
endmodule

// File: rtl/async_rx_core.sv
module async_rx_core
  import arx_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                base_tick,
  input  logic                rxd,
  input  logic [1:0]          cfg_len_code,
  input  logic                cfg_par_en,
  input  logic                cfg_par_odd,
  input  logic                cfg_stop2,
  input  logic                cfg_msb_first,
  input  logic                cfg_invert,
  input  logic                cfg_os8,
  input  logic                cfg_os6,
  input  logic                cfg_edge_start,
  input  logic                cfg_mp_mode,
  input  logic                mp_wake_arm,
  input  logic                cmp_enable,
  input  logic                cmp_id_only,
  input  logic [CMP_W-1:0]    cmp_value,
  input  logic                flag_clr,
  output logic [MAX_DATA-1:0] rx_data,
  output logic                rx_mpb,
  output logic                rx_strobe,
  output logic                rx_full,
  output logic                err_parity,
  output logic                err_frame,
  output logic                err_overrun,
  output logic                cmp_match,
  output logic                mp_wake_on
);
  logic [PERIOD_W-1:0]    period;
  logic [FRAME_IDX_W-1:0] clen, nbits;
  logic [MAX_FRAME-1:0]   frame_bits;
  logic                   frame_done;
  rx_word_t               word;

  assign period = bit_period(cfg_os8, cfg_os6);
  assign clen   = char_len(cfg_len_code);
  assign nbits  = frame_len(clen, cfg_par_en, cfg_mp_mode, cfg_stop2);

  arx_sampler #(.FRAME_W(MAX_FRAME), .PER_W(PERIOD_W)) u_samp (
    .clk        (clk),
    .rst_n      (rst_n),
    .base_tick  (base_tick),
    .rxd        (rxd),
    .edge_start (cfg_edge_start),
    .period     (period),
    .nbits      (nbits),
    .frame      (frame_bits),
    .frame_done (frame_done)
  );

  arx_decoder u_dec (
    .frame     (frame_bits),
    .len       (clen),
    .par_en    (cfg_par_en),
    .par_odd   (cfg_par_odd),
    .mp_mode   (cfg_mp_mode),
    .stop2     (cfg_stop2),
    .msb_first (cfg_msb_first),
    .invert    (cfg_invert),
    .word      (word)
  );

  arx_flags u_flags (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_done  (frame_done),
    .word        (word),
    .mp_mode     (cfg_mp_mode),
    .wake_arm    (mp_wake_arm),
    .cmp_enable  (cmp_enable),
    .cmp_id_only (cmp_id_only),
    .cmp_value   (cmp_value),
    .flag_clr    (flag_clr),
    .rx_data     (rx_data),
    .rx_mpb      (rx_mpb),
    .rx_strobe   (rx_strobe),
    .rx_full     (rx_full),
    .err_parity  (err_parity),
    .err_frame   (err_frame),
    .err_overrun (err_overrun),
    .cmp_match   (cmp_match),
    .wake_on     (mp_wake_on)
  );
endmodule

// File: tb/sim_async_rx_core.sv
`timescale 1ns/1ps
module sim_async_rx_core;
  logic       clk = 1'b0, rst_n = 1'b0, base_tick = 1'b0, rxd = 1'b1;
  logic [1:0] cfg_len_code = 2'b10;
  logic cfg_par_en = 0, cfg_par_odd = 0, cfg_stop2 = 0, cfg_msb_first = 0, cfg_invert = 0;
  logic cfg_os8 = 0, cfg_os6 = 0, cfg_edge_start = 0, cfg_mp_mode = 0, mp_wake_arm = 0;
  logic cmp_enable = 0, cmp_id_only = 0, flag_clr = 0;
  logic [7:0] cmp_value = 8'h00;
  logic [8:0] rx_data;
  logic rx_mpb, rx_strobe, rx_full, err_parity, err_frame, err_overrun, cmp_match, mp_wake_on;

  async_rx_core u0 (.*);

  always #4 clk = ~clk;

  int n_chk = 0, n_bad = 0, tick_div = 1, n_strobe = 0, e_strobe = 0;
  logic [8:0] e_data = '0;
  bit e_mpb, e_full, e_per, e_fer, e_ore, e_match, e_wake;

  // base tick: one clock in every tick_div clocks
  initial begin
    int c = 0;
    forever begin
      @(negedge clk);
      c = (c + 1 >= tick_div) ? 0 : c + 1;
      base_tick = (c == 0);
    end
  end

  always @(negedge clk) if (rst_n && rx_strobe) n_strobe++;

  function automatic int cur_period();
    return cfg_os6 ? 6 : (cfg_os8 ? 8 : 16);
  endfunction
  function automatic int cur_len();
    return !cfg_len_code[1] ? 9 : (cfg_len_code[0] ? 7 : 8);
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic chk_all(input string req);
    chk(req, "rx_data", 32'(rx_data), 32'(e_data));
    chk(req, "rx_mpb", 32'(rx_mpb), 32'(e_mpb));
    chk(req, "rx_full", 32'(rx_full), 32'(e_full));
    chk(req, "err_parity", 32'(err_parity), 32'(e_per));
    chk(req, "err_frame", 32'(err_frame), 32'(e_fer));
    chk(req, "err_overrun", 32'(err_overrun), 32'(e_ore));
    chk(req, "cmp_match", 32'(cmp_match), 32'(e_match));
    chk(req, "mp_wake_on", 32'(mp_wake_on), 32'(e_wake));
    chk(req, "strobes", 32'(n_strobe), 32'(e_strobe));
  endtask

  // behavioural reference for one completed frame
  task automatic model(input int v, input bit mpb, input bit pbad, input bit sbad);
    int l = cur_len();
    int mask = (1 << l) - 1;
    int d;
    bit m = cfg_mp_mode ? mpb : 1'b0;
    if (cfg_mp_mode && e_wake && !m) return;
    if (cfg_mp_mode && e_wake) e_wake = 0;
    if (e_full) begin
      e_ore = 1;
      return;
    end
    d = cfg_invert ? (~v & mask) : (v & mask);
    e_full = 1;
    e_data = d[8:0];
    e_mpb = m;
    e_strobe++;
    if (cfg_par_en && pbad) e_per = 1;
    if (sbad) e_fer = 1;
    if (cmp_enable && (!cmp_id_only || m) && ((d & 255) == int'(cmp_value))) e_match = 1;
  endtask

  task automatic send(input int v, input bit mpb, input bit pbad, input bit s1bad, input bit s2bad);
    int p = cur_period();
    int l = cur_len();
    bit par;
    bit q[$];
    q.push_back(1'b0);
    for (int i = 0; i < l; i++) q.push_back(cfg_msb_first ? v[l - 1 - i] : v[i]);
    par = cfg_par_odd;
    for (int i = 0; i < l; i++) par = par ^ v[i];
    if (cfg_par_en) q.push_back(par ^ pbad);
    if (cfg_mp_mode) q.push_back(mpb);
    q.push_back(!s1bad);
    if (cfg_stop2) q.push_back(!s2bad);
    foreach (q[i]) begin
      rxd = q[i];
      repeat (p * tick_div) @(negedge clk);
    end
    rxd = 1'b1;
    repeat (2 * p * tick_div) @(negedge clk);
    model(v, mpb, pbad, s1bad || (cfg_stop2 && s2bad));
  endtask

  task automatic clr();
    @(negedge clk) flag_clr = 1'b1;
    @(negedge clk) flag_clr = 1'b0;
    e_full = 0; e_per = 0; e_fer = 0; e_ore = 0; e_match = 0;
  endtask

  task automatic arm();
    @(negedge clk) mp_wake_arm = 1'b1;
    @(negedge clk) mp_wake_arm = 1'b0;
    e_wake = 1;
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog all actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    chk_all("R1");

    // R2 lengths
    send(8'hA5, 0, 0, 0, 0); chk_all("R2"); clr();
    cfg_len_code = 2'b11; send(8'hBA, 0, 0, 0, 0); chk_all("R2"); clr();
    cfg_len_code = 2'b00; send(9'h1C3, 0, 0, 0, 0); chk_all("R2"); clr();
    cfg_len_code = 2'b10;

    // R3 parity
    cfg_par_en = 1; send(8'h07, 0, 0, 0, 0); chk_all("R3"); clr();
    cfg_par_odd = 1; send(8'h5C, 0, 0, 0, 0); chk_all("R3"); clr();
    send(8'h5D, 0, 1, 0, 0); chk_all("R3"); clr();
    cfg_par_odd = 0; send(8'h21, 0, 1, 0, 0); chk_all("R3"); clr();
    cfg_par_en = 0;

    // R4 stop bits
    send(8'h66, 0, 0, 1, 0); chk_all("R4"); clr();
    cfg_stop2 = 1; send(8'h99, 0, 0, 0, 0); chk_all("R4"); clr();
    send(8'h98, 0, 0, 0, 1); chk_all("R4"); clr();
    cfg_stop2 = 0;

    // R5 bit period
    cfg_os8 = 1; send(8'h3C, 0, 0, 0, 0); chk_all("R5"); clr();
    cfg_os6 = 1; send(8'hC3, 0, 0, 0, 0); chk_all("R5"); clr();
    cfg_os6 = 0; tick_div = 2; send(8'h5A, 0, 0, 0, 0); chk_all("R5"); clr();
    tick_div = 1; cfg_os8 = 0;
    repeat (10) @(negedge clk);

    // R8 order, R9 inversion
    cfg_msb_first = 1; send(8'hC4, 0, 0, 0, 0); chk_all("R8"); clr();
    cfg_len_code = 2'b00; send(9'h10B, 0, 0, 0, 0); chk_all("R8"); clr();
    cfg_len_code = 2'b10; cfg_msb_first = 0;
    cfg_invert = 1; send(8'h0F, 0, 0, 0, 0); chk_all("R9"); clr();
    cfg_par_en = 1; send(8'h31, 0, 0, 0, 0); chk_all("R9"); clr();
    cfg_par_en = 0; cfg_invert = 0;

    // R7 glitch
    rxd = 1'b0; repeat (4) @(negedge clk); rxd = 1'b1;
    repeat (48) @(negedge clk); chk_all("R7");

    // R6 level start: held-low line yields repeated frames -> overrun
    rxd = 1'b0; repeat (30 * 16) @(negedge clk); rxd = 1'b1;
    repeat (12 * 16) @(negedge clk);
    e_full = 1; e_data = '0; e_mpb = 0; e_fer = 1; e_ore = 1; e_strobe++;
    chk_all("R6"); clr();
    // R6 edge start: a single frame only
    cfg_edge_start = 1;
    rxd = 1'b0; repeat (30 * 16) @(negedge clk); rxd = 1'b1;
    repeat (12 * 16) @(negedge clk);
    e_full = 1; e_data = '0; e_fer = 1; e_strobe++;
    chk_all("R6"); clr();
    send(8'h2B, 0, 0, 0, 0); chk_all("R6"); clr();
    cfg_edge_start = 0;

    // R10 marker bit
    cfg_mp_mode = 1;
    send(8'h12, 1, 0, 0, 0); chk_all("R10"); clr();
    send(8'h34, 0, 0, 0, 0); chk_all("R10"); clr();

    // R11 wake-up filter
    arm(); chk_all("R11");
    send(8'h44, 0, 0, 0, 0); chk_all("R11");
    send(8'h47, 0, 0, 1, 0); chk_all("R11");
    send(8'h45, 1, 0, 0, 0); chk_all("R11"); clr();
    send(8'h46, 0, 0, 0, 0); chk_all("R11"); clr();
    cfg_mp_mode = 0;

    // R12 compare
    cmp_enable = 1; cmp_value = 8'h5A;
    send(8'h33, 0, 0, 0, 0); chk_all("R12"); clr();
    send(8'h5A, 0, 0, 0, 0); chk_all("R12"); clr();
    cfg_mp_mode = 1; cmp_id_only = 1;
    send(8'h5A, 0, 0, 0, 0); chk_all("R12"); clr();
    send(8'h5A, 1, 0, 0, 0); chk_all("R12"); clr();
    cfg_mp_mode = 0; cmp_id_only = 0; cmp_enable = 0;

    // R13 overrun
    send(8'h11, 0, 0, 0, 0);
    send(8'h22, 0, 0, 1, 0); chk_all("R13");

    // R14 clear
    clr(); chk_all("R14");
    finish_run();
  end
endmodule